// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block sits at the retire end of an out-of-order pipeline and decides, separately for each hardware thread, when the in-flight work of that thread has to be thrown away. Three kinds of request can ask for this. The execute stage can report a branch mispredict or a memory-order violation. A fault at retire can start a trap, and the trap squashes once a programmable delay has elapsed. A thread-context write can ask for the whole thread to be flushed. For each thread the block drops stale requests, picks one winner per cycle, works out the boundary sequence number, and tracks the thread's commit state. It then drives a registered feedback bundle back to the earlier stages: a squash pulse, a reorder-buffer-squashing level, the boundary sequence number, a branch-taken flag and a redirect PC.

The reorder-buffer walk that removes entries is not part of this block. The block only learns through a done input that the walk has finished. Newly renamed instructions arrive as a valid-only stream, one per thread per cycle. The stream has no ready signal and is never held back. An entry that arrives while the thread is not running is dropped, and only its effect on youngest-sequence tracking is lost. Sequence numbers are unsigned and compared without wraparound.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset every thread is running (state code 0), and fb_squash_o, fb_robsq_o, fb_done_seq_o, fb_taken_o and fb_pc_o are all zero.
- R2: An execute squash request is taken only if the thread is not trap pending and its sequence number is less than or equal to the tracked youngest sequence number. Otherwise it is ignored and causes no squash pulse.
- R3: For a taken execute squash, the boundary is the request's sequence number, or that number minus one when the include flag is set. The boundary appears on fb_done_seq_o and also becomes the tracked youngest sequence number.
- R4: For a taken execute squash, fb_taken_o is the reported taken bit OR'd with (mispredict AND unconditional), and fb_pc_o is the request's PC.
- R5: A fault while running moves the thread to trap pending (state code 2). The trap squash happens on the max(L,1)-th clock edge after the fault edge, where L is trap_lat_i sampled at the fault.
- R6: At most one squash happens per thread per cycle, chosen in this order: trap, then thread-context, then execute. While a thread is trap pending, thread-context and execute requests are ignored.
- R7: A trap or thread-context squash flushes the whole thread. Its boundary is last_seq_i when rob_empty_i is high, and rob_head_seq_i minus one otherwise. It drives fb_pc_o from restart_pc_i and fb_taken_o to 0.
- R8: Each squash is followed by a one-cycle fb_squash_o pulse, and the thread enters reorder-buffer squashing (state code 1). fb_robsq_o stays high for every cycle in that state. rob_done_i, with no new squash in the same cycle, returns the thread to running.
- R9: A valid inserted instruction updates the youngest sequence number only while the thread is running and no squash is taken in that cycle.
- R10: state_o gives each thread's state in 2 bits: 0 running, 1 reorder-buffer squashing, 2 trap pending. A fault outside the running state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat_i | input | LAT_W | Trap squash delay in cycles, sampled at each fault |
| ex_vld_i | input | NT | Execute squash request, one bit per thread |
| ex_seq_i | input | NT*SEQ_W | Squashed sequence number per thread |
| ex_incl_i | input | NT | Include the squashing instruction itself |
| ex_mispred_i | input | NT | Request comes from a branch mispredict |
| ex_uncond_i | input | NT | Mispredicted branch is unconditional |
| ex_taken_i | input | NT | Taken outcome reported by execute |
| ex_pc_i | input | NT*PC_W | Redirect PC from execute |
| fault_i | input | NT | Instruction at retire has faulted |
| ctx_req_i | input | NT | Thread-context flush request |
| rob_empty_i | input | NT | Thread has no reorder-buffer entries |
| rob_head_seq_i | input | NT*SEQ_W | Sequence number at the reorder-buffer head |
| last_seq_i | input | NT*SEQ_W | Last retired sequence number |
| restart_pc_i | input | NT*PC_W | Restart PC for whole-thread flushes |
| ins_vld_i | input | NT | Insert stream valid, one bit per thread |
| ins_seq_i | input | NT*SEQ_W | Sequence number of the inserted instruction |
| rob_done_i | input | NT | Reorder-buffer walk has finished |
| fb_squash_o | output | NT | One-cycle squash pulse |
| fb_robsq_o | output | NT | Reorder-buffer squashing level |
| fb_done_seq_o | output | NT*SEQ_W | Boundary sequence number of the last squash |
| fb_taken_o | output | NT | Branch-taken flag of the last squash |
| fb_pc_o | output | NT*PC_W | Redirect PC of the last squash |
| state_o | output | NT*2 | Thread state code |

## Verification
Directed sequences come first. One places an execute squash exactly at the youngest sequence number and another one above it, which separates the accept and reject sides of the stale filter. One raises thread-context and execute requests together, which shows the priority order. One inserts during a flush, which shows whether insertions are gated. One faults with a latency of three and then offers competing requests while the trap is pending, which pins down both the trap delay and the blocking of other sources. After these, a seeded random mix drives both threads at once, with short sequence ranges so that stale and accepted squashes both occur often. Every cycle this mix compares state, the pulse and the fed-back fields against a bench model, and it tells trap, flush and execute boundaries apart by source.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ROBSQ = 2'd1,
    ST_TRAP  = 2'd2
  } csq_state_e;

  // grant vector bit positions, highest index has highest priority
  localparam int GNT_EXE  = 0;
  localparam int GNT_CTX  = 1;
  localparam int GNT_TRAP = 2;
  localparam int GNT_N    = 3;
endpackage

// File: rtl/csq_src_pick.sv
module csq_src_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;

  // ripple from the top index down: the first request seen wins
  assign taken[N] = 1'b0;
  for (genvar i = N - 1; i >= 0; i--) begin : g_pri
    assign gnt_o[i] = req_i[i] && !taken[i+1];
    assign taken[i] = taken[i+1] | req_i[i];
  end
endmodule

// File: rtl/csq_trap_timer.sv
module csq_trap_timer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             fire_o
);
  logic             armed_q;
  logic [LAT_W-1:0] cnt_q;

  assign fire_o = armed_q && (cnt_q <= LAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= lat_i;
    end else if (fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5: an armed timer that has not fired counts down by exactly one
  assert_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !fire_o && !start_i) |=> (armed_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5: a start always arms the timer
  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> armed_q);
endmodule

// File: rtl/csq_thread.sv
module csq_thread
  import csq_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] trap_lat_i,
  input  logic             ex_vld_i,
  input  logic [SEQ_W-1:0] ex_seq_i,
  input  logic             ex_incl_i,
  input  logic             ex_mispred_i,
  input  logic             ex_uncond_i,
  input  logic             ex_taken_i,
  input  logic [PC_W-1:0]  ex_pc_i,
  input  logic             fault_i,
  input  logic             ctx_req_i,
  input  logic             rob_empty_i,
  input  logic [SEQ_W-1:0] rob_head_seq_i,
  input  logic [SEQ_W-1:0] last_seq_i,
  input  logic [PC_W-1:0]  restart_pc_i,
  input  logic             ins_vld_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic             rob_done_i,
  output logic             squash_o,
  output logic             robsq_o,
  output logic [SEQ_W-1:0] done_seq_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [1:0]       state_o
);
  csq_state_e       state_q;
  logic [SEQ_W-1:0] young_q;
  logic             squash_q;
  logic [SEQ_W-1:0] done_q;
  logic             taken_q;
  logic [PC_W-1:0]  pc_q;

  logic             trap_fire;
  logic             ex_ok;
  logic             ctx_ok;
  logic [GNT_N-1:0] gnt;
  logic             any_sq;
  logic             trap_start;
  logic [SEQ_W-1:0] ex_bnd;
  logic [SEQ_W-1:0] full_bnd;

  // stale filter: an execute squash must not be younger than the youngest entry
  always_comb begin
    ex_ok  = ex_vld_i && (state_q != ST_TRAP) && (ex_seq_i <= young_q);
    ctx_ok = ctx_req_i && (state_q != ST_TRAP);
  end

  csq_src_pick #(.N(GNT_N)) pick_i (
    .req_i ({trap_fire, ctx_ok, ex_ok}),
    .gnt_o (gnt)
  );

  assign any_sq     = |gnt;
  assign trap_start = !any_sq && (state_q == ST_RUN) && fault_i;
  assign ex_bnd     = ex_incl_i ? ex_seq_i - 1'b1 : ex_seq_i;
  assign full_bnd   = rob_empty_i ? last_seq_i : rob_head_seq_i - 1'b1;

  csq_trap_timer #(.LAT_W(LAT_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (trap_start),
    .lat_i   (trap_lat_i),
    .fire_o  (trap_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      young_q  <= '0;
      squash_q <= 1'b0;
      done_q   <= '0;
      taken_q  <= 1'b0;
      pc_q     <= '0;
    end else begin
      squash_q <= any_sq;
      if (any_sq) begin
        state_q <= ST_ROBSQ;
        if (gnt[GNT_EXE]) begin
          done_q  <= ex_bnd;
          young_q <= ex_bnd;
          taken_q <= ex_taken_i | (ex_mispred_i & ex_uncond_i);
          pc_q    <= ex_pc_i;
        end else begin
          done_q  <= full_bnd;
          young_q <= full_bnd;
          taken_q <= 1'b0;
          pc_q    <= restart_pc_i;
        end
      end else begin
        if (state_q == ST_RUN && ins_vld_i) young_q <= ins_seq_i;
        if (trap_start) state_q <= ST_TRAP;
        else if (state_q == ST_ROBSQ && rob_done_i) state_q <= ST_RUN;
      end
    end
  end

  assign squash_o   = squash_q;
  assign robsq_o    = (state_q == ST_ROBSQ);
  assign done_seq_o = done_q;
  assign taken_o    = taken_q;
  assign pc_o       = pc_q;
  assign state_o    = state_q;

  // R2: a request younger than the youngest entry yields no pulse
  assert_stale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld_i && !ctx_ok && !trap_fire && ex_seq_i > young_q) |=> !squash_q);

  // R6: while trap pending and not firing, nothing else squashes
  assert_trap_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TRAP && !trap_fire) |=> (state_q == ST_TRAP && !squash_q));

  // R3: after a squash the youngest tracker equals the reported boundary
  assert_young_R3: assert property (@(posedge clk) disable iff (!rst_n)
    squash_q |-> (young_q == done_q));

  // R8: done from the walk returns the thread to running
  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ROBSQ && rob_done_i && !any_sq) |=> (state_q == ST_RUN));

  // R9: no update of the youngest tracker outside the running state
  assert_ins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && !any_sq) |=> $stable(young_q));

  // R4: an unconditional mispredict always reports taken
  assert_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[GNT_EXE] && ex_mispred_i && ex_uncond_i) |=> taken_q);
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
  parameter int NT    = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int LAT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LAT_W-1:0]    trap_lat_i,
  input  logic [NT-1:0]       ex_vld_i,
  input  logic [NT*SEQ_W-1:0] ex_seq_i,
  input  logic [NT-1:0]       ex_incl_i,
  input  logic [NT-1:0]       ex_mispred_i,
  input  logic [NT-1:0]       ex_uncond_i,
  input  logic [NT-1:0]       ex_taken_i,
  input  logic [NT*PC_W-1:0]  ex_pc_i,
  input  logic [NT-1:0]       fault_i,
  input  logic [NT-1:0]       ctx_req_i,
  input  logic [NT-1:0]       rob_empty_i,
  input  logic [NT*SEQ_W-1:0] rob_head_seq_i,
  input  logic [NT*SEQ_W-1:0] last_seq_i,
  input  logic [NT*PC_W-1:0]  restart_pc_i,
  input  logic [NT-1:0]       ins_vld_i,
  input  logic [NT*SEQ_W-1:0] ins_seq_i,
  input  logic [NT-1:0]       rob_done_i,
  output logic [NT-1:0]       fb_squash_o,
  output logic [NT-1:0]       fb_robsq_o,
  output logic [NT*SEQ_W-1:0] fb_done_seq_o,
  output logic [NT-1:0]       fb_taken_o,
  output logic [NT*PC_W-1:0]  fb_pc_o,
  output logic [NT*2-1:0]     state_o
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    csq_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W)) thr_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .trap_lat_i     (trap_lat_i),
      .ex_vld_i       (ex_vld_i[t]),
      .ex_seq_i       (ex_seq_i[t*SEQ_W +: SEQ_W]),
      .ex_incl_i      (ex_incl_i[t]),
      .ex_mispred_i   (ex_mispred_i[t]),
      .ex_uncond_i    (ex_uncond_i[t]),
      .ex_taken_i     (ex_taken_i[t]),
      .ex_pc_i        (ex_pc_i[t*PC_W +: PC_W]),
      .fault_i        (fault_i[t]),
      .ctx_req_i      (ctx_req_i[t]),
      .rob_empty_i    (rob_empty_i[t]),
      .rob_head_seq_i (rob_head_seq_i[t*SEQ_W +: SEQ_W]),
      .last_seq_i     (last_seq_i[t*SEQ_W +: SEQ_W]),
      .restart_pc_i   (restart_pc_i[t*PC_W +: PC_W]),
      .ins_vld_i      (ins_vld_i[t]),
      .ins_seq_i      (ins_seq_i[t*SEQ_W +: SEQ_W]),
      .rob_done_i     (rob_done_i[t]),
      .squash_o       (fb_squash_o[t]),
      .robsq_o        (fb_robsq_o[t]),
      .done_seq_o     (fb_done_seq_o[t*SEQ_W +: SEQ_W]),
      .taken_o        (fb_taken_o[t]),
      .pc_o           (fb_pc_o[t*PC_W +: PC_W]),
      .state_o        (state_o[t*2 +: 2])
    );
  end
endmodule

// File: tb/commit_squash_ctrl_tb_top.sv
module commit_squash_ctrl_tb_top;
  localparam int NT = 2;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [LW-1:0] b_lat;
  logic b_ex_vld[NT], b_ex_incl[NT], b_ex_mis[NT], b_ex_unc[NT], b_ex_tk[NT];
  logic [SW-1:0] b_ex_seq[NT], b_head[NT], b_last[NT], b_ins_seq[NT];
  logic [PW-1:0] b_ex_pc[NT], b_rpc[NT];
  logic b_fault[NT], b_ctx[NT], b_empty[NT], b_ins[NT], b_done[NT];

  logic [NT-1:0] p_ex_vld, p_ex_incl, p_ex_mis, p_ex_unc, p_ex_tk;
  logic [NT-1:0] p_fault, p_ctx, p_empty, p_ins, p_done;
  logic [NT*SW-1:0] p_ex_seq, p_head, p_last, p_ins_seq;
  logic [NT*PW-1:0] p_ex_pc, p_rpc;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      p_ex_vld[t] = b_ex_vld[t]; p_ex_incl[t] = b_ex_incl[t];
      p_ex_mis[t] = b_ex_mis[t]; p_ex_unc[t] = b_ex_unc[t];
      p_ex_tk[t] = b_ex_tk[t]; p_fault[t] = b_fault[t]; p_ctx[t] = b_ctx[t];
      p_empty[t] = b_empty[t]; p_ins[t] = b_ins[t]; p_done[t] = b_done[t];
      p_ex_seq[t*SW +: SW] = b_ex_seq[t]; p_head[t*SW +: SW] = b_head[t];
      p_last[t*SW +: SW] = b_last[t]; p_ins_seq[t*SW +: SW] = b_ins_seq[t];
      p_ex_pc[t*PW +: PW] = b_ex_pc[t]; p_rpc[t*PW +: PW] = b_rpc[t];
    end
  end

  logic [NT-1:0] o_sq, o_rsq, o_tk;
  logic [NT*SW-1:0] o_done;
  logic [NT*PW-1:0] o_pc;
  logic [NT*2-1:0] o_st;

  commit_squash_ctrl #(.NT(NT), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_lat_i(b_lat),
    .ex_vld_i(p_ex_vld), .ex_seq_i(p_ex_seq), .ex_incl_i(p_ex_incl),
    .ex_mispred_i(p_ex_mis), .ex_uncond_i(p_ex_unc), .ex_taken_i(p_ex_tk),
    .ex_pc_i(p_ex_pc), .fault_i(p_fault), .ctx_req_i(p_ctx),
    .rob_empty_i(p_empty), .rob_head_seq_i(p_head), .last_seq_i(p_last),
    .restart_pc_i(p_rpc), .ins_vld_i(p_ins), .ins_seq_i(p_ins_seq),
    .rob_done_i(p_done), .fb_squash_o(o_sq), .fb_robsq_o(o_rsq),
    .fb_done_seq_o(o_done), .fb_taken_o(o_tk), .fb_pc_o(o_pc), .state_o(o_st)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench reference model state
  int m_stat[NT], m_cnt[NT], m_src[NT];
  bit m_armed[NT], m_sq[NT], m_tk[NT];
  logic [SW-1:0] m_young[NT], m_done[NT];
  logic [PW-1:0] m_pc[NT];

  function automatic logic [SW-1:0] f_ex_bnd(logic [SW-1:0] s, logic incl);
    return incl ? s - 16'd1 : s;
  endfunction
  function automatic logic [SW-1:0] f_full_bnd(logic emp, logic [SW-1:0] hd, logic [SW-1:0] ls);
    return emp ? ls : hd - 16'd1;
  endfunction
  function automatic bit f_taken(logic tk, logic mis, logic unc);
    return tk | (mis & unc);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int t = 0; t < NT; t++) begin
      b_ex_vld[t] = 0; b_ex_incl[t] = 0; b_ex_mis[t] = 0; b_ex_unc[t] = 0;
      b_ex_tk[t] = 0; b_ex_seq[t] = 0; b_ex_pc[t] = 0; b_fault[t] = 0;
      b_ctx[t] = 0; b_empty[t] = 1; b_head[t] = 0; b_last[t] = 0;
      b_rpc[t] = 0; b_ins[t] = 0; b_ins_seq[t] = 0; b_done[t] = 0;
    end
  endtask

  task automatic model_next();
    for (int t = 0; t < NT; t++) begin
      bit fire, exok, ctxok, start;
      int src;
      fire  = m_armed[t] && (m_cnt[t] <= 1);
      exok  = b_ex_vld[t] && m_stat[t] != 2 && b_ex_seq[t] <= m_young[t];
      ctxok = b_ctx[t] && m_stat[t] != 2;
      src   = fire ? 1 : ctxok ? 2 : exok ? 3 : 0;
      start = (src == 0) && (m_stat[t] == 0) && b_fault[t];
      if (start) begin m_armed[t] = 1; m_cnt[t] = int'(b_lat); end
      else if (fire) m_armed[t] = 0;
      else if (m_armed[t]) m_cnt[t]--;
      m_sq[t] = (src != 0);
      if (src != 0) m_src[t] = src;
      if (src != 0) begin
        m_stat[t] = 1;
        if (src == 3) begin
          m_done[t] = f_ex_bnd(b_ex_seq[t], b_ex_incl[t]);
          m_tk[t] = f_taken(b_ex_tk[t], b_ex_mis[t], b_ex_unc[t]);
          m_pc[t] = b_ex_pc[t];
        end else begin
          m_done[t] = f_full_bnd(b_empty[t], b_head[t], b_last[t]);
          m_tk[t] = 0;
          m_pc[t] = b_rpc[t];
        end
        m_young[t] = m_done[t];
      end else begin
        if (m_stat[t] == 0 && b_ins[t]) m_young[t] = b_ins_seq[t];
        if (start) m_stat[t] = 2;
        else if (m_stat[t] == 1 && b_done[t]) m_stat[t] = 0;
      end
    end
  endtask

  task automatic compare();
    for (int t = 0; t < NT; t++) begin
      string rq;
      chk(o_st[t*2 +: 2] == 2'(m_stat[t]), (m_stat[t] == 2) ? "R5" : "R10",
          "state", o_st[t*2 +: 2], m_stat[t]);
      chk(o_rsq[t] == (m_stat[t] == 1), "R8", "robsq", o_rsq[t], m_stat[t] == 1);
      rq = !m_sq[t] ? "R2" : (m_src[t] == 1) ? "R5" : (m_src[t] == 2) ? "R7" : "R6";
      chk(o_sq[t] == m_sq[t], rq, "squash", o_sq[t], m_sq[t]);
      if (m_sq[t]) begin
        rq = (m_src[t] == 3) ? "R3" : "R7";
        chk(o_done[t*SW +: SW] == m_done[t], rq, "done_seq", o_done[t*SW +: SW], m_done[t]);
        rq = (m_src[t] == 3) ? "R4" : "R7";
        chk(o_tk[t] == m_tk[t], rq, "taken", o_tk[t], m_tk[t]);
        chk(o_pc[t*PW +: PW] == m_pc[t], rq, "pc", o_pc[t*PW +: PW], m_pc[t]);
      end
    end
  endtask

  task automatic cycle();
    model_next();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    clr();
    b_lat = 4'd0;
    for (int t = 0; t < NT; t++) begin
      m_stat[t] = 0; m_cnt[t] = 0; m_src[t] = 0; m_armed[t] = 0; m_sq[t] = 0;
      m_tk[t] = 0; m_young[t] = 0; m_done[t] = 0; m_pc[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(o_st == '0, "R1", "state", o_st, 0);
    chk(o_sq == '0 && o_rsq == '0 && o_tk == '0, "R1", "flags", {o_sq, o_rsq, o_tk}, 0);
    chk(o_done == '0 && o_pc == '0, "R1", "fields", o_done, 0);
    cycle();

    // R9 insert while running, then stale filter boundaries (R2)
    b_ins[0] = 1; b_ins_seq[0] = 16'd20; cycle(); clr();
    b_ex_vld[0] = 1; b_ex_seq[0] = 16'd21; cycle(); clr();
    chk(o_sq[0] == 0, "R2", "younger squash ignored", o_sq[0], 0);
    b_ex_vld[0] = 1; b_ex_seq[0] = 16'd20; b_ex_incl[0] = 1; b_ex_mis[0] = 1;
    b_ex_unc[0] = 1; b_ex_pc[0] = 32'h100; cycle(); clr();
    chk(o_sq[0] == 1, "R2", "equal squash accepted", o_sq[0], 1);
    chk(o_done[15:0] == 16'd19, "R3", "include boundary", o_done[15:0], 19);
    chk(o_tk[0] == 1, "R4", "uncond forces taken", o_tk[0], 1);
    b_done[0] = 1; cycle(); clr();
    chk(o_st[1:0] == 2'd0, "R8", "done returns running", o_st[1:0], 0);

    // R6 thread-context beats execute in the same cycle
    b_ins[0] = 1; b_ins_seq[0] = 16'd30; cycle(); clr();
    b_ctx[0] = 1; b_ex_vld[0] = 1; b_ex_seq[0] = 16'd5; b_empty[0] = 0;
    b_head[0] = 16'd25; b_rpc[0] = 32'h2000; cycle(); clr();
    chk(o_done[15:0] == 16'd24, "R6", "ctx wins boundary", o_done[15:0], 24);
    chk(o_pc[31:0] == 32'h2000, "R7", "restart pc", o_pc[31:0], 32'h2000);

    // R9 insert during squashing is dropped
    b_ins[0] = 1; b_ins_seq[0] = 16'd60; cycle(); clr();
    b_done[0] = 1; cycle(); clr();
    b_ex_vld[0] = 1; b_ex_seq[0] = 16'd50; cycle(); clr();
    chk(o_sq[0] == 0, "R9", "insert while squashing ignored", o_sq[0], 0);
    b_done[0] = 1; cycle(); clr();

    // R5 trap with latency 3, requests blocked meanwhile (R6)
    b_lat = 4'd3; b_fault[0] = 1; cycle(); clr();
    chk(o_st[1:0] == 2'd2, "R5", "trap pending", o_st[1:0], 2);
    b_ctx[0] = 1; b_ex_vld[0] = 1; b_ex_seq[0] = 16'd1; cycle(); clr();
    chk(o_sq[0] == 0, "R6", "blocked during trap", o_sq[0], 0);
    b_last[0] = 16'd7; cycle();
    chk(o_sq[0] == 0, "R5", "no early trap squash", o_sq[0], 0);
    cycle(); clr();
    chk(o_sq[0] == 1, "R5", "trap squash on third edge", o_sq[0], 1);
    chk(o_done[15:0] == 16'd7, "R7", "empty rob boundary", o_done[15:0], 7);
    b_done[0] = 1; cycle(); clr();
    b_fault[0] = 1; b_ex_vld[0] = 0; cycle(); clr();
    // fault now ignored? state was running so trap starts; let it expire
    repeat (4) cycle();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      clr();
      b_lat = 4'($urandom_range(0, 5));
      for (int t = 0; t < NT; t++) begin
        b_ex_vld[t]  = ($urandom_range(0, 3) == 0);
        b_ex_seq[t]  = 16'($urandom_range(1, 63));
        b_ex_incl[t] = 1'($urandom);
        b_ex_mis[t]  = 1'($urandom);
        b_ex_unc[t]  = 1'($urandom);
        b_ex_tk[t]   = 1'($urandom);
        b_ex_pc[t]   = $urandom;
        b_fault[t]   = ($urandom_range(0, 19) == 0);
        b_ctx[t]     = ($urandom_range(0, 19) == 0);
        b_empty[t]   = ($urandom_range(0, 3) == 0);
        b_head[t]    = 16'($urandom_range(1, 63));
        b_last[t]    = 16'($urandom_range(0, 63));
        b_rpc[t]     = $urandom;
        b_ins[t]     = 1'($urandom);
        b_ins_seq[t] = 16'($urandom_range(1, 63));
        b_done[t]    = ($urandom_range(0, 2) == 0);
      end
      cycle();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule